// File: doc/BRIEF.md
# UART Automatic RTS/CTS Flow Control

This unit sits beside a small UART and handles hardware handshaking on both directions of the link. It owns an 8-bit control byte with these fields:

- receiver and transmitter enables
- independent enables for automatic RTS and automatic CTS handling
- a 2-bit RTS release threshold
- separate polarity inversion for the two handshake pins

The unit takes the receive FIFO occupancy as an input. From it, the unit drives the RTS pin, so the remote sender is told to pause once only a few free slots are left.

In the other direction, the CTS pin is brought into the local clock domain through a synchronizer. It then gates a "may start next character" permission for the transmitter. A character that is already on the line is never cut short, because only the start of the next character is held back.

When automatic RTS is off, the RTS pin simply follows a level written by software. The receiver enable is brought out as a write permission for the receive FIFO, so no character enters the FIFO while the receiver is off.

Top module: `uflow_ctrl`

## Requirements
- R1: After a synchronous reset the control byte reads 0x03 (both enables set, every flow-control field clear), rts_pin is 0, tx_start_ok is 1 and rx_write_ok is 1.
- R2: A write stores reg_wr_data into the control byte at the next rising edge, and reg_rd_data returns it. The field layout is:
  - bit 0: receiver on
  - bit 1: transmitter on
  - bit 2: automatic RTS
  - bit 3: automatic CTS
  - bits 5:4: RTS threshold select
  - bit 6: RTS invert
  - bit 7: CTS invert
- R3: With automatic RTS on, RTS is logically asserted while the free slot count (8 minus rx_level, taken as 0 when rx_level is 8 or more) is greater than the release count. The release count is 3 for select 00, 2 for 01, 1 for 10 and 4 for 11. rts_pin shows this one clock after the inputs.
- R4: With automatic RTS on and the RTS invert bit set, rts_pin is the complement of the R3 level.
- R5: With automatic RTS off, rts_pin equals sw_rts one clock later, whatever rx_level and the RTS invert bit are.
- R6: cts_pin passes through two flops. A change on it reaches tx_start_ok after the second rising edge, not the first.
- R7: With automatic CTS on, the transmitter on, and CTS invert clear, tx_start_ok is 0 while the synchronized CTS is 0 and 1 while it is 1.
- R8: With automatic CTS on and CTS invert set, a synchronized CTS of 1 holds off the transmitter and a 0 lets it start.
- R9: With automatic CTS off, cts_pin has no effect: tx_start_ok equals the transmitter-on bit.
- R10: With the transmitter-on bit clear, tx_start_ok is 0 in every mode.
- R11: rx_write_ok equals the receiver-on bit, so the FIFO occupancy cannot rise while the receiver is off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr_en | input | 1 | Write strobe for the control byte |
| reg_wr_data | input | 8 | Control byte to store |
| reg_rd_data | output | 8 | Current control byte |
| sw_rts | input | 1 | Software RTS level used when automatic RTS is off |
| rx_level | input | 4 | Receive FIFO occupancy (0 to 8) |
| rx_write_ok | output | 1 | Receive FIFO may accept characters |
| tx_start_ok | output | 1 | Transmitter may begin the next character |
| cts_pin | input | 1 | Asynchronous CTS pin |
| rts_pin | output | 1 | RTS pin |

## Verification
A wrong control byte is visible on reg_rd_data the cycle after the write. It also shows in the mode-dependent behaviour of rts_pin and tx_start_ok from the same cycle.

A threshold decode or free-slot error shows as a wrong rts_pin level one clock after the FIFO level crosses the boundary. The boundary in question is the one for the selected release count.

A synchronizer with the wrong depth or reset value shows as tx_start_ok moving one edge early or late after a CTS change. The reference model follows every cycle, so each of these faults is reported in the cycle where it first reaches a port.

// File: rtl/uflow_pkg.sv
package uflow_pkg;

    localparam int CTRL_W = 8;

    typedef struct packed {
        logic       cts_inv;
        logic       rts_inv;
        logic [1:0] rts_sel;
        logic       auto_cts;
        logic       auto_rts;
        logic       tx_on;
        logic       rx_on;
    } ctrl_t;

    localparam ctrl_t CTRL_RST = '{
        cts_inv : 1'b0, rts_inv : 1'b0, rts_sel : 2'b00,
        auto_cts: 1'b0, auto_rts: 1'b0, tx_on  : 1'b1, rx_on: 1'b1
    };

    // Free-slot count at which RTS is released; encoding is not monotonic.
    function automatic logic [2:0] rts_release_slots(input logic [1:0] sel);
        logic [2:0] n;
        case (sel)
            2'b00:   n = 3'd3;
            2'b01:   n = 3'd2;
            2'b10:   n = 3'd1;
            default: n = 3'd4;
        endcase
        return n;
    endfunction

endpackage

// File: rtl/uflow_ctrl_reg.sv
module uflow_ctrl_reg
    import uflow_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [CTRL_W-1:0] wr_data,
    output ctrl_t             ctrl_o
);
    always_ff @(posedge clk) begin
        if (rst)
            ctrl_o <= CTRL_RST;
        else if (wr_en)
            ctrl_o <= ctrl_t'(wr_data);
    end
endmodule

// File: rtl/uflow_cts_sync.sv
module uflow_cts_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic async_i,
    output logic sync_o
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst)
            chain <= '0;
        else
            chain <= {chain[STAGES-2:0], async_i};
    end

    assign sync_o = chain[STAGES-1];
endmodule

// File: rtl/uflow_rts_gen.sv
module uflow_rts_gen
    import uflow_pkg::*;
#(
    parameter int DEPTH = 8,
    localparam int LVL_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             auto_rts,
    input  logic             rts_inv,
    input  logic [1:0]       rts_sel,
    input  logic [LVL_W-1:0] level,
    input  logic             sw_rts,
    output logic             rts_o
);
    logic [LVL_W-1:0] free_slots;
    logic [LVL_W-1:0] release_at;
    logic             rts_logic;
    logic             rts_next;

    always_comb begin
        if (level >= LVL_W'(DEPTH))
            free_slots = '0;
        else
            free_slots = LVL_W'(DEPTH) - level;
        release_at = LVL_W'(rts_release_slots(rts_sel));
        rts_logic  = (free_slots > release_at);
        rts_next   = auto_rts ? (rts_logic ^ rts_inv) : sw_rts;
    end

    always_ff @(posedge clk) begin
        if (rst)
            rts_o <= 1'b0;
        else
            rts_o <= rts_next;
    end
endmodule

// File: rtl/uflow_ctrl.sv
module uflow_ctrl
    import uflow_pkg::*;
#(
    parameter int DEPTH       = 8,
    parameter int SYNC_STAGES = 2,
    localparam int LVL_W      = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr_en,
    input  logic [CTRL_W-1:0] reg_wr_data,
    output logic [CTRL_W-1:0] reg_rd_data,
    input  logic              sw_rts,
    input  logic [LVL_W-1:0]  rx_level,
    output logic              rx_write_ok,
    output logic              tx_start_ok,
    input  logic              cts_pin,
    output logic              rts_pin
);
    ctrl_t ctrl;
    logic  cts_s;

    uflow_ctrl_reg u_reg (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (reg_wr_en),
        .wr_data (reg_wr_data),
        .ctrl_o  (ctrl)
    );

    uflow_cts_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst     (rst),
        .async_i (cts_pin),
        .sync_o  (cts_s)
    );

    uflow_rts_gen #(.DEPTH(DEPTH)) u_rts (
        .clk      (clk),
        .rst      (rst),
        .auto_rts (ctrl.auto_rts),
        .rts_inv  (ctrl.rts_inv),
        .rts_sel  (ctrl.rts_sel),
        .level    (rx_level),
        .sw_rts   (sw_rts),
        .rts_o    (rts_pin)
    );

    // Only the start of a character is gated; a running shift completes.
    always_comb begin
        reg_rd_data = CTRL_W'(ctrl);
        rx_write_ok = ctrl.rx_on;
        tx_start_ok = ctrl.tx_on & (~ctrl.auto_cts | (cts_s ^ ctrl.cts_inv));
    end
endmodule

// File: rtl/uflow_ctrl_chk.sv
module uflow_ctrl_chk #(
    parameter int DEPTH = 8,
    localparam int LVL_W = $clog2(DEPTH + 1)
) (
    input logic             clk,
    input logic             rst,
    input logic [7:0]       reg_rd_data,
    input logic [LVL_W-1:0] rx_level,
    input logic             sw_rts,
    input logic             rx_write_ok,
    input logic             tx_start_ok,
    input logic             rts_pin
);
    int  free_c;
    int  rel_c;
    logic exp_auto;

    always_comb begin
        free_c = (int'(rx_level) >= DEPTH) ? 0 : DEPTH - int'(rx_level);
        unique case (reg_rd_data[5:4])
            2'b00: rel_c = 3;
            2'b01: rel_c = 2;
            2'b10: rel_c = 1;
            default: rel_c = 4;
        endcase
        exp_auto = (free_c > rel_c) ^ reg_rd_data[6];
    end

    p_rts_auto_r3: assert property (@(posedge clk) disable iff (rst)
        reg_rd_data[2] |=> (rts_pin == $past(exp_auto)));

    p_rts_manual_r5: assert property (@(posedge clk) disable iff (rst)
        !reg_rd_data[2] |=> (rts_pin == $past(sw_rts)));

    p_cts_ignored_r9: assert property (@(posedge clk) disable iff (rst)
        (!reg_rd_data[3]) |-> (tx_start_ok == reg_rd_data[1]));

    p_tx_off_r10: assert property (@(posedge clk) disable iff (rst)
        !reg_rd_data[1] |-> !tx_start_ok);

    p_rx_gate_r11: assert property (@(posedge clk) disable iff (rst)
        rx_write_ok == reg_rd_data[0]);
endmodule

bind uflow_ctrl uflow_ctrl_chk #(.DEPTH(DEPTH)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .reg_rd_data (reg_rd_data),
    .rx_level    (rx_level),
    .sw_rts      (sw_rts),
    .rx_write_ok (rx_write_ok),
    .tx_start_ok (tx_start_ok),
    .rts_pin     (rts_pin)
);

// File: tb/uflow_ctrl_bench.sv
module uflow_ctrl_bench;
    localparam int DEPTH = 8;
    localparam int LW    = $clog2(DEPTH + 1);

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          reg_wr_en = 1'b0;
    logic [7:0]    reg_wr_data = 8'h00;
    logic          sw_rts = 1'b0;
    logic          cts_pin = 1'b0;
    logic [LW-1:0] rx_level = '0;
    logic [7:0]    reg_rd_data;
    logic          rx_write_ok, tx_start_ok, rts_pin;

    uflow_ctrl u_uflow_ctrl (
        .clk(clk), .rst(rst), .reg_wr_en(reg_wr_en), .reg_wr_data(reg_wr_data),
        .reg_rd_data(reg_rd_data), .sw_rts(sw_rts), .rx_level(rx_level),
        .rx_write_ok(rx_write_ok), .tx_start_ok(tx_start_ok),
        .cts_pin(cts_pin), .rts_pin(rts_pin)
    );

    always #5 clk = ~clk;

    int checks = 0;
    int errors = 0;

    // Behavioural reference state
    int m_ctrl = 3;
    int m_s1 = 0, m_s2 = 0, m_rts = 0;

    function automatic int rel_slots(input int sel);
        if (sel == 0) return 3;
        if (sel == 1) return 2;
        if (sel == 2) return 1;
        return 4;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_ctrl = 3; m_s1 = 0; m_s2 = 0; m_rts = 0;
        end else begin
            int free;
            int lvl;
            lvl  = int'(rx_level);
            free = (lvl >= DEPTH) ? 0 : DEPTH - lvl;
            if (m_ctrl[2])
                m_rts = ((free > rel_slots((m_ctrl >> 4) & 3)) ? 1 : 0) ^ m_ctrl[6];
            else
                m_rts = sw_rts;
            m_s2 = m_s1;
            m_s1 = cts_pin;
            if (reg_wr_en) m_ctrl = reg_wr_data;
        end
    end

    task automatic chk(input int got, input int exp, input string tag, input string what);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s %s: got %0d expected %0d at %0t", tag, what, got, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (!rst) begin
            int exp_tx;
            string rt, tt;
            chk(reg_rd_data, m_ctrl & 8'hFF, "R2", "control readback");
            chk(rx_write_ok, m_ctrl[0], "R11", "rx write permission");
            rt = m_ctrl[2] ? (m_ctrl[6] ? "R4" : "R3") : "R5";
            chk(rts_pin, m_rts, rt, "rts pin");
            if (!m_ctrl[1])      begin exp_tx = 0;                 tt = "R10"; end
            else if (!m_ctrl[3]) begin exp_tx = 1;                 tt = "R9";  end
            else if (m_ctrl[7])  begin exp_tx = m_s2 ^ 1;          tt = "R8";  end
            else                 begin exp_tx = m_s2;              tt = "R7";  end
            chk(tx_start_ok, exp_tx, tt, "tx start permission");
        end
    end

    task automatic wr(input logic [7:0] v);
        @(negedge clk);
        reg_wr_en = 1'b1; reg_wr_data = v;
        @(negedge clk);
        reg_wr_en = 1'b0;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state
        chk(reg_rd_data, 8'h03, "R1", "reset control byte");
        chk(rts_pin, 0, "R1", "reset rts");
        chk(tx_start_ok, 1, "R1", "reset tx permission");
        chk(rx_write_ok, 1, "R1", "reset rx permission");
        rst = 1'b0;

        // R6: two-edge CTS latency with auto CTS on
        wr(8'h0B);
        cts_pin = 1'b1;
        repeat (3) @(negedge clk);
        chk(tx_start_ok, 1, "R6", "cts high settled");
        cts_pin = 1'b0;
        @(negedge clk);
        chk(tx_start_ok, 1, "R6", "after one edge");
        @(negedge clk);
        chk(tx_start_ok, 0, "R6", "after two edges");

        // R3/R4: threshold sweep over every select, both polarities, all levels
        for (int inv = 0; inv < 2; inv++) begin
            for (int sel = 0; sel < 4; sel++) begin
                wr(8'(8'h07 | (sel << 4) | (inv << 6)));
                for (int lv = 0; lv <= 10; lv++) begin
                    rx_level = LW'(lv);
                    @(negedge clk);
                end
            end
        end

        // R5: manual RTS ignores level and invert
        wr(8'h43);
        for (int i = 0; i < 12; i++) begin
            sw_rts = i[0]; rx_level = LW'(i % 9);
            @(negedge clk);
        end

        // Random mix of writes, levels and pins
        for (int i = 0; i < 4000; i++) begin
            reg_wr_en   = ($urandom_range(0, 7) == 0);
            reg_wr_data = 8'($urandom);
            rx_level    = LW'($urandom_range(0, 11));
            sw_rts      = 1'($urandom);
            if ($urandom_range(0, 3) == 0) cts_pin = ~cts_pin;
            @(negedge clk);
        end
        reg_wr_en = 1'b0;
        @(negedge clk);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule